// File: doc/BRIEF.md
# Panel Temperature Threshold Monitor

This block runs panel-temperature measurements only when the host asks for one. A trigger pulse from the host sends a one-cycle start request to an external converter. The block then stays busy until the converter returns a done strobe with a signed 8-bit reading in degrees Celsius. That reading replaces the previous one in the result register. In the same step it is checked against a programmable upper limit, a programmable lower limit and a drift window around a stored baseline.

Each check that trips sets a sticky flag. Flag bit 0 is the hot flag, bit 1 the cold flag and bit 2 the drift flag. The flags stay set until the host reads them, which the host signals with a one-cycle read strobe. A per-flag mask chooses which flags pull the active-low interrupt line down. The mask never stops a flag from setting. The first reading after reset becomes the baseline, and the baseline moves to the current reading each time the drift flag fires.

Top module: `tmon_irq_top`

## Requirements
- R1: When `trig_i` is high in a cycle where `busy_o` is low, `conv_start_o` is high for exactly the next cycle. `busy_o` rises in that same next cycle and stays high until the cycle after `conv_done_i` is seen.
- R2: A `trig_i` pulse that arrives while `busy_o` is high produces no start pulse and does not extend the busy period.
- R3: A `conv_done_i` seen while busy loads `conv_data_i` into `result_o` one cycle later. A `conv_done_i` seen while idle leaves `result_o` and the flags unchanged.
- R4: A completed reading that is strictly greater than `hot_lim_i` sets flag bit 0. Both values are compared as signed numbers, and a reading equal to the limit does not set the flag.
- R5: A completed reading that is strictly less than `cold_lim_i` sets flag bit 1. Both values are compared as signed numbers, and a reading equal to the limit does not set the flag.
- R6: A completed reading whose absolute difference from the baseline is strictly greater than the unsigned `delta_i` sets flag bit 2. `delta_i` = 0 disables this check, and the first reading after reset never sets bit 2.
- R7: The baseline takes the value of the first reading after reset. It is reloaded with the current reading only when bit 2 is set by that reading; otherwise it is kept.
- R8: Flags are sticky, and a high `flag_rd_i` clears all of them one cycle later. A flag set by a reading that completes in the same cycle as the read stays set.
- R9: With the default parameters, `irq_n_o` is low exactly while some bit of `flags_o & mask_i` is set. Masked flags still set and still show on `flags_o`.
- R10: While reset is held, `conv_start_o`, `busy_o`, `result_o` and `flags_o` are all zero and `irq_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Host measurement trigger pulse |
| conv_start_o | output | 1 | One-cycle start request to the converter |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 8 | Signed reading in degrees Celsius, valid with done |
| hot_lim_i | input | 8 | Signed upper limit |
| cold_lim_i | input | 8 | Signed lower limit |
| delta_i | input | 4 | Unsigned drift threshold; 0 disables the drift check |
| mask_i | input | 3 | Per-flag interrupt enable (bit 0 hot, bit 1 cold, bit 2 drift) |
| flag_rd_i | input | 1 | Host read of the flag register; clears the flags |
| result_o | output | 8 | Last completed reading |
| flags_o | output | 3 | Sticky flags (bit 0 hot, bit 1 cold, bit 2 drift) |
| busy_o | output | 1 | Measurement in progress |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Two collisions can occur in one cycle. The first is a host flag read landing on the cycle in which a conversion completes: the old flags must clear while the newly raised flag survives. The second is a fresh trigger landing on the done cycle, which must be dropped because the block is still busy. The bench provokes both by driving the done strobe together with the read strobe, and separately together with the trigger. A behavioural model advanced on every clock decides the expected flags, busy state and start pulse for the following cycle.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   localparam int NFLAG    = 3;
   localparam int FLG_HOT  = 0;
   localparam int FLG_COLD = 1;
   localparam int FLG_CHG  = 2;
endpackage

// File: rtl/tmon_conv_ctrl.sv
module tmon_conv_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic done_i,
   output logic start_o,
   output logic busy_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         busy_o  <= 1'b0;
      end else begin
         start_o <= trig_i && !busy_o;
         if (busy_o) begin
            if (done_i) busy_o <= 1'b0;
         end else if (trig_i) begin
            busy_o <= 1'b1;
         end
      end
   end

   // R1
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> busy_o);
   // R2
   busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !start_o);
endmodule

// File: rtl/tmon_eval.sv
module tmon_eval
   import tmon_pkg::*;
#(
   parameter int TW = 8,
   parameter int DW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic [TW-1:0]    data_i,
   input  logic [TW-1:0]    hot_i,
   input  logic [TW-1:0]    cold_i,
   input  logic [DW-1:0]    delta_i,
   output logic [TW-1:0]    result_o,
   output logic [NFLAG-1:0] set_o
);
   localparam int XW = TW + 1;

   if (TW < 4) begin : bad_tw
      $error("tmon_eval: TW must be at least 4");
   end
   if (DW > TW) begin : bad_dw
      $error("tmon_eval: DW must not exceed TW");
   end

   logic [TW-1:0]        base_q;
   logic                 base_vld_q;
   logic signed [XW-1:0] diff;
   logic [XW-1:0]        mag;
   logic                 drift;

   always_comb begin
      diff  = $signed({data_i[TW-1], data_i}) - $signed({base_q[TW-1], base_q});
      mag   = diff[XW-1] ? XW'(-diff) : XW'(diff);
      drift = base_vld_q && (delta_i != '0) && (mag > XW'(delta_i));
   end

   always_comb begin
      set_o           = '0;
      set_o[FLG_HOT]  = capture_i && ($signed(data_i) > $signed(hot_i));
      set_o[FLG_COLD] = capture_i && ($signed(data_i) < $signed(cold_i));
      set_o[FLG_CHG]  = capture_i && drift;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o   <= '0;
         base_q     <= '0;
         base_vld_q <= 1'b0;
      end else if (capture_i) begin
         result_o   <= data_i;
         base_vld_q <= 1'b1;
         if (!base_vld_q || drift) base_q <= data_i;
      end
   end

   // R3
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(result_o));
   // R7
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (base_vld_q && !set_o[FLG_CHG]) |=> $stable(base_q));
   // R6
   first_no_drift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !base_vld_q |-> !set_o[FLG_CHG]);
endmodule

// File: rtl/tmon_flags.sv
module tmon_flags
   import tmon_pkg::*;
#(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_i,
   input  logic             clr_i,
   input  logic [NFLAG-1:0] mask_i,
   output logic [NFLAG-1:0] flags_o,
   output logic             irq_n_o
);
   for (genvar g = 0; g < NFLAG; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flags_o[g] <= 1'b0;
         else if (set_i[g])  flags_o[g] <= 1'b1;
         else if (clr_i)     flags_o[g] <= 1'b0;
      end
   end

   logic any_pend;
   assign any_pend = |(flags_o & mask_i);

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n_o <= 1'b1;
         else        irq_n_o <= !any_pend;
      end
   end else begin : g_irq_comb
      assign irq_n_o = !any_pend;
   end

   // R8
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
   // R8
   flags_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/tmon_irq_top.sv
module tmon_irq_top
   import tmon_pkg::*;
#(
   parameter int TW      = 8,
   parameter int DW      = 4,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   output logic             conv_start_o,
   input  logic             conv_done_i,
   input  logic [TW-1:0]    conv_data_i,
   input  logic [TW-1:0]    hot_lim_i,
   input  logic [TW-1:0]    cold_lim_i,
   input  logic [DW-1:0]    delta_i,
   input  logic [NFLAG-1:0] mask_i,
   input  logic             flag_rd_i,
   output logic [TW-1:0]    result_o,
   output logic [NFLAG-1:0] flags_o,
   output logic             busy_o,
   output logic             irq_n_o
);
   logic             capture;
   logic [NFLAG-1:0] set_w;

   assign capture = conv_done_i && busy_o;

   tmon_conv_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig_i),
      .done_i  (conv_done_i),
      .start_o (conv_start_o),
      .busy_o  (busy_o)
   );

   tmon_eval #(.TW(TW), .DW(DW)) u_eval (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .data_i    (conv_data_i),
      .hot_i     (hot_lim_i),
      .cold_i    (cold_lim_i),
      .delta_i   (delta_i),
      .result_o  (result_o),
      .set_o     (set_w)
   );

   tmon_flags #(.REG_IRQ(REG_IRQ)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_w),
      .clr_i   (flag_rd_i),
      .mask_i  (mask_i),
      .flags_o (flags_o),
      .irq_n_o (irq_n_o)
   );

   // R9
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i == '0 && !REG_IRQ) |-> irq_n_o);
   // R3
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && !busy_o && !flag_rd_i) |=> $stable(flags_o));
endmodule

// File: tb/tmon_irq_top_tb.sv
module tmon_irq_top_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig = 1'b0, done = 1'b0, rd = 1'b0;
   logic [7:0] data = '0, hot = 8'd40, cold = 8'd0;
   logic [3:0] delta = 4'd5;
   logic [2:0] mask = 3'b111;
   logic       start_w, busy_w, irq_w;
   logic [7:0] res_w;
   logic [2:0] flg_w;

   int n_chk = 0, n_err = 0;
   string phase = "R10";

   always #(CLK_P/2) clk = ~clk;

   tmon_irq_top dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .conv_start_o(start_w),
      .conv_done_i(done), .conv_data_i(data), .hot_lim_i(hot),
      .cold_lim_i(cold), .delta_i(delta), .mask_i(mask), .flag_rd_i(rd),
      .result_o(res_w), .flags_o(flg_w), .busy_o(busy_w), .irq_n_o(irq_w)
   );

   // behavioural reference
   bit m_busy, m_start, m_bvld;
   int m_res, m_base;
   bit [2:0] m_flags;

   task automatic cmp(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s (%s) t=%0t: actual %0d expected %0d", req, phase, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_start = 0; m_bvld = 0; m_res = 0; m_base = 0; m_flags = '0;
      end else begin
         bit [2:0] s;
         int d, df;
         s = '0;
         if (m_busy && done) begin
            d = int'($signed(data));
            if (d > int'($signed(hot)))  s[0] = 1;
            if (d < int'($signed(cold))) s[1] = 1;
            df = d - m_base;
            if (df < 0) df = -df;
            if (m_bvld && delta != 0 && df > int'(delta)) begin s[2] = 1; m_base = d; end
            if (!m_bvld) begin m_base = d; m_bvld = 1; end
            m_res = d;
         end
         m_flags = (rd ? 3'b000 : m_flags) | s;
         m_start = !m_busy && trig;
         m_busy  = m_busy ? !done : trig;
      end
      #(CLK_P/4);
      cmp("R1 start",  int'(start_w), int'(m_start));
      cmp("R1 busy",   int'(busy_w),  int'(m_busy));
      cmp("R3 result", int'($signed(res_w)), m_res);
      cmp("R4 hot",    int'(flg_w[0]), int'(m_flags[0]));
      cmp("R5 cold",   int'(flg_w[1]), int'(m_flags[1]));
      cmp("R6 change", int'(flg_w[2]), int'(m_flags[2]));
      cmp("R9 irq",    int'(irq_w), int'(!(|(m_flags & mask))));
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(int val, int lat);
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0;
      cyc(lat);
      done = 1; data = 8'(val);
      @(negedge clk); done = 0;
   endtask

   task automatic read_flags();
      @(negedge clk); rd = 1;
      @(negedge clk); rd = 0;
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      phase = "R6 first reading";
      measure(25, 2);
      phase = "R6 within window";
      measure(30, 1);
      phase = "R7 drift reload";
      measure(31, 3);
      measure(37, 1);
      read_flags();
      phase = "R4 above limit";
      measure(41, 2);
      read_flags();
      phase = "R4 equal limit";
      measure(40, 1);
      phase = "R5 below limit";
      measure(-10, 2);
      read_flags();
      phase = "R5 equal limit";
      measure(0, 1);
      read_flags();
      phase = "R2 trigger while busy";
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0;
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 1; done = 1; data = 8'd2;
      @(negedge clk); trig = 0; done = 0;
      cyc(2);
      phase = "R3 done while idle";
      @(negedge clk); done = 1; data = 8'd80;
      @(negedge clk); done = 0;
      cyc(2);
      phase = "R9 masked";
      mask = 3'b000;
      measure(85, 1);
      cyc(2);
      mask = 3'b010;
      cyc(2);
      mask = 3'b001;
      cyc(2);
      read_flags();
      mask = 3'b111;
      phase = "R8 read with completion";
      measure(60, 1);
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0;
      @(negedge clk); done = 1; data = 8'd20; rd = 1;
      @(negedge clk); done = 0; rd = 0;
      cyc(2);
      read_flags();
      phase = "R6 disabled";
      delta = 4'd0;
      measure(-10, 1);
      measure(70, 1);
      delta = 4'd15;
      phase = "R6 max window";
      measure(55, 1);
      measure(71, 1);
      read_flags();
      phase = "R10 reset";
      @(negedge clk); trig = 1;
      @(negedge clk); trig = 0; rst_n = 0;
      cyc(3);
      rst_n = 1;
      phase = "R7 baseline after reset";
      measure(-5, 1);
      measure(5, 1);
      cyc(3);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule